// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects up to 31 interrupt sources and gives each one a programmable 3-bit priority. It tells the processor the highest priority that is currently pending. When the processor runs an acknowledge cycle for a given level, the block returns a vector number. That number is a programmable base plus the index of the winning source. Index 0 is never a source. It is kept for the spurious vector, which is returned when nothing is pending at the requested level.

Software programs the block through a simple word-wide register bus. Four control words each hold eight 4-bit source fields. Bit 3 of each field acts as a write qualifier, so one word write can reprogram or acknowledge any subset of the eight sources and leave the others untouched. A priority of zero masks a source. A parameter selects which sources are edge-latched; the rest are level inputs. For edge sources, a transition word chooses the active edge of each one. A small two-state machine handles the acknowledge handshake. In ACK_IDLE it waits for a request. On a request it captures the vector and takes the transition IDLE->RESPOND. In ACK_RESPOND it presents the captured vector for one cycle and always takes the transition RESPOND->IDLE.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every priority is 0, every edge latch is clear, the transition word reads 0, the vector base reads 64, irq_level is 0 and iack_valid is 0.
- R2: Source n (1..31) lives in control word address (n-1)/8, in the field whose lowest bit is 28-4*((n-1)%8): the first source of a group takes bits 31:28. On read, field bits 2:0 give the priority and bit 3 gives the pending state. Field 7 of address 3 reads 0.
- R3: On a write to a control word, a field with bit 3 set loads bits 2:0 as that source's priority. A field with bit 3 clear leaves that source's priority unchanged.
- R4: A control-word write with bit 3 set in a source's field clears that source's edge latch. A level source's pending state always equals its input and is not changed by such a write.
- R5: The transition word at address 4 holds source n in bit 32-n. For an edge source, a 1 latches pending on a rising input and a 0 latches pending on a falling input. The opposite edge sets nothing.
- R6: A pending source with priority 0 does not raise irq_level and is never returned as a vector.
- R7: irq_level equals the highest priority among sources that are pending and have a nonzero priority, and 0 when there is none.
- R8: When iack_req is sampled high in ACK_IDLE, iack_valid is high in the next cycle only. iack_vector then equals base plus the lowest source index that is pending with priority equal to iack_level.
- R9: When no source is pending at the requested level, including a request for level 0, the returned vector is the base itself (the spurious vector).
- R10: The vector base is read and written in bits 7:0 at address 5. A new base is used by the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 31 | Source inputs, bit k is source k+1 |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 3 | Word address: 0-3 control, 4 transition, 5 base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_level | output | 3 | Highest pending enabled priority |
| iack_req | input | 1 | Acknowledge request |
| iack_level | input | 3 | Level being acknowledged |
| iack_valid | output | 1 | One-cycle vector valid |
| iack_vector | output | 8 | Vector number |

## Verification
The bench places several pending sources on one level. A resolver that scans the wrong way would return the highest index instead of the lowest. It also checks that a masked source is left out: a design that ignores priority 0 would raise the level or hand out that vector. The bench writes words with bit 3 clear in most fields. A design that did not honour the qualifier would wipe neighbouring priorities or acknowledge sources that were never targeted. The edge tests cover both polarities and the opposite edge, and they apply an acknowledge write to a level source, which must stay pending. Other tests request a level that has no pending source and hold the request for two cycles; a faulty handshake would return a stale vector or a double pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        ACK_IDLE    = 1'b0,
        ACK_RESPOND = 1'b1
    } ack_state_t;

    // lowest bit of the 4-bit field for zero-based source k
    function automatic int fld_lsb(input int k);
        return 28 - 4 * (k % 8);
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int           NUM_SRC   = 31,
    parameter logic [30:0]  EDGE_MASK = 31'h0000_00FF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] pol_rise,
    input  logic [NUM_SRC-1:0] ack,
    output logic [NUM_SRC-1:0] pend
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        if (EDGE_MASK[k]) begin : g_edge
            logic prev_q;
            logic hit_q;
            logic evt;
            assign evt = pol_rise[k] ? (src_in[k] & ~prev_q) : (~src_in[k] & prev_q);
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    hit_q  <= 1'b0;
                end else begin
                    prev_q <= src_in[k];
                    if (evt)
                        hit_q <= 1'b1;
                    else if (ack[k])
                        hit_q <= 1'b0;
                end
            end
            assign pend[k] = hit_q;
        end else begin : g_level
            logic lvl_unused;
            assign lvl_unused = pol_rise[k] ^ ack[k];
            assign pend[k]    = src_in[k];
        end
    end

endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              req_level,
    output logic [PRIO_W-1:0]              max_level,
    output logic [IDX_W-1:0]               win_idx
);

    always_comb begin
        max_level = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (pend[k] && prio[k] > max_level)
                max_level = prio[k];
        end
    end

    // scan downward so the lowest index is assigned last
    always_comb begin
        win_idx = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (pend[k] && prio[k] != '0 && prio[k] == req_level)
                win_idx = IDX_W'(k + 1);
        end
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iack_req,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [VEC_W-1:0] vec_base,
    output logic             iack_valid,
    output logic [VEC_W-1:0] iack_vector
);

    ack_state_t state_q, state_d;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:    if (iack_req) state_d = ACK_RESPOND;
            ACK_RESPOND: state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACK_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ACK_IDLE && iack_req)
                vec_q <= vec_base + VEC_W'(win_idx);
        end
    end

    always_comb begin
        iack_valid  = 1'b0;
        iack_vector = '0;
        unique case (state_q)
            ACK_IDLE:    ;
            ACK_RESPOND: begin
                iack_valid  = 1'b1;
                iack_vector = vec_q;
            end
        endcase
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int           NUM_SRC   = 31,
    parameter int           PRIO_W    = 3,
    parameter int           VEC_W     = 8,
    parameter int           ADDR_W    = 3,
    parameter logic [7:0]   BASE_RST  = 8'd64,
    parameter logic [30:0]  EDGE_MASK = 31'h0000_00FF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [PRIO_W-1:0]  irq_level,
    input  logic               iack_req,
    input  logic [PRIO_W-1:0]  iack_level,
    output logic               iack_valid,
    output logic [VEC_W-1:0]   iack_vector
);

    localparam int NUM_CTRL   = (NUM_SRC + 7) / 8;
    localparam int ADDR_TRANS = NUM_CTRL;
    localparam int ADDR_BASE  = NUM_CTRL + 1;
    localparam int IDX_W      = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [NUM_SRC-1:0]             pol_rise;
    logic [NUM_SRC-1:0]             ack;
    logic [NUM_SRC-1:0]             pend;
    logic [VEC_W-1:0]               vec_base;
    logic [IDX_W-1:0]               win_idx;
    logic                           wr_en;

    assign wr_en = bus_sel & bus_wr;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_ack
        localparam int LSB = fld_lsb(k);
        assign ack[k] = wr_en && (bus_addr == ADDR_W'(k / 8)) && bus_wdata[LSB + 3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio     <= '0;
            pol_rise <= '0;
            vec_base <= BASE_RST;
        end else if (wr_en) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (ack[k])
                    prio[k] <= bus_wdata[fld_lsb(k) +: PRIO_W];
                if (bus_addr == ADDR_W'(ADDR_TRANS))
                    pol_rise[k] <= bus_wdata[31 - k];
            end
            if (bus_addr == ADDR_W'(ADDR_BASE))
                vec_base <= bus_wdata[VEC_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (bus_addr == ADDR_W'(k / 8))
                bus_rdata[fld_lsb(k) +: 4] = {pend[k], prio[k]};
            if (bus_addr == ADDR_W'(ADDR_TRANS))
                bus_rdata[31 - k] = pol_rise[k];
        end
        if (bus_addr == ADDR_W'(ADDR_BASE))
            bus_rdata[VEC_W-1:0] = vec_base;
    end

    irq_src_latch #(
        .NUM_SRC  (NUM_SRC),
        .EDGE_MASK(EDGE_MASK)
    ) u_latch (
        .clk     (clk),
        .rst     (rst),
        .src_in  (irq_src),
        .pol_rise(pol_rise),
        .ack     (ack),
        .pend    (pend)
    );

    irq_resolve #(
        .NUM_SRC(NUM_SRC),
        .PRIO_W (PRIO_W)
    ) u_resolve (
        .pend     (pend),
        .prio     (prio),
        .req_level(iack_level),
        .max_level(irq_level),
        .win_idx  (win_idx)
    );

    irq_ack_fsm #(
        .IDX_W(IDX_W),
        .VEC_W(VEC_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .iack_req   (iack_req),
        .win_idx    (win_idx),
        .vec_base   (vec_base),
        .iack_valid (iack_valid),
        .iack_vector(iack_vector)
    );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 8,
    parameter int ADDR_W  = 3
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           bus_sel,
    input logic                           bus_wr,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [31:0]                    bus_wdata,
    input logic                           iack_req,
    input logic [PRIO_W-1:0]              iack_level,
    input logic                           iack_valid,
    input logic [VEC_W-1:0]               iack_vector,
    input logic [PRIO_W-1:0]              irq_level,
    input logic [VEC_W-1:0]               vec_base,
    input logic [NUM_SRC-1:0]             pend,
    input logic [NUM_SRC-1:0][PRIO_W-1:0] prio
);

    // R8: the vector strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        iack_valid |=> !iack_valid);

    // R8: a strobe is always preceded by a request
    a_r8_after_req: assert property (@(posedge clk) disable iff (rst)
        iack_valid |-> $past(iack_req));

    // R9: acknowledging level 0 yields the spurious vector
    a_r9_spurious_lvl0: assert property (@(posedge clk) disable iff (rst)
        (iack_valid && $past(iack_level) == '0) |-> iack_vector == $past(vec_base));

    // R3: a write with the qualifier clear keeps source 1's priority
    a_r3_keep_prio: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == '0 && !bus_wdata[31]) |=> prio[0] == $past(prio[0]));

    // R7: a nonzero level needs some pending source
    a_r7_level_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq_level != '0 |-> pend != '0);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC(NUM_SRC),
    .PRIO_W (PRIO_W),
    .VEC_W  (VEC_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .iack_req   (iack_req),
    .iack_level (iack_level),
    .iack_valid (iack_valid),
    .iack_vector(iack_vector),
    .irq_level  (irq_level),
    .vec_base   (vec_base),
    .pend       (pend),
    .prio       (prio)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [30:0] irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_level;
    logic        iack_req = 1'b0;
    logic [2:0]  iack_level = '0;
    logic        iack_valid;
    logic [7:0]  iack_vector;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst(rst), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .iack_req(iack_req), .iack_level(iack_level),
        .iack_valid(iack_valid), .iack_vector(iack_vector)
    );

    // {sources[30:0], requested level, expected irq_level, expected vector}
    localparam logic [44:0] TBL [10] = '{
        {31'h0000_0000, 3'd5, 3'd0, 8'd64},
        {31'h0000_0100, 3'd3, 3'd3, 8'd73},
        {31'h0000_0300, 3'd5, 3'd5, 8'd74},
        {31'h0000_0600, 3'd5, 3'd5, 8'd74},
        {31'h0000_0500, 3'd3, 3'd5, 8'd73},
        {31'h0000_0800, 3'd0, 3'd0, 8'd64},
        {31'h0000_1800, 3'd7, 3'd7, 8'd77},
        {31'h4000_0000, 3'd2, 3'd2, 8'd95},
        {31'h4000_0100, 3'd2, 3'd3, 8'd95},
        {31'h4000_1000, 3'd4, 3'd7, 8'd64}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic iack(input logic [2:0] lvl, output logic v, output logic [7:0] vec);
        @(negedge clk);
        iack_req = 1'b1; iack_level = lvl;
        @(negedge clk);
        v = iack_valid; vec = iack_vector;
        iack_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        v;
        logic [7:0]  vec;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d); check("R1 word reset", d, 32'h0);
        end
        rd(3'd5, d); check("R1 base reset", d, 32'd64);
        check("R1 level reset", {29'h0, irq_level}, 32'h0);
        check("R1 valid reset", {31'h0, iack_valid}, 32'h0);

        // program: src9=3 src10=5 src11=5 src12=0 src13=7, src31=2
        wr(3'd1, 32'hBDD8_F000);
        wr(3'd3, 32'h0000_00A0);
        rd(3'd1, d); check("R2 word1 layout", d, 32'h3550_7000);
        rd(3'd3, d); check("R2 word3 layout", d, 32'h0000_0020);

        // table walk: R6 R7 R8 R9
        foreach (TBL[i]) begin
            @(negedge clk);
            irq_src = TBL[i][44:14];
            #1;
            check("R7 R6 level", {29'h0, irq_level}, {29'h0, TBL[i][10:8]});
            iack(TBL[i][13:11], v, vec);
            check("R8 valid", {31'h0, v}, 32'h1);
            check("R8 R9 vector", {24'h0, vec}, {24'h0, TBL[i][7:0]});
        end
        irq_src = '0;

        // R3 qualifier: only src10 changes
        wr(3'd1, 32'h0E00_0000);
        rd(3'd1, d); check("R3 qualifier", d, 32'h3650_7000);

        // R5 falling polarity (reset), src1 prio 4
        wr(3'd0, 32'hC000_0000);
        @(negedge clk); irq_src[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd0, d); check("R5 rising ignored when falling", d, 32'h4000_0000);
        irq_src[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(3'd0, d); check("R5 falling latches", d, 32'hC000_0000);
        check("R7 edge level", {29'h0, irq_level}, 32'd4);
        iack(3'd4, v, vec); check("R8 edge vector", {24'h0, vec}, 32'd65);
        wr(3'd0, 32'hC000_0000);
        rd(3'd0, d); check("R4 ack clears", d, 32'h4000_0000);
        check("R4 level after ack", {29'h0, irq_level}, 32'h0);

        // R5 rising polarity for src2, prio 1
        wr(3'd4, 32'h4000_0000);
        rd(3'd4, d); check("R5 transition readback", d, 32'h4000_0000);
        wr(3'd0, 32'h0900_0000);
        @(negedge clk); irq_src[1] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd0, d); check("R5 rising latches", d, 32'h4900_0000);
        check("R7 src2 level", {29'h0, irq_level}, 32'd1);
        wr(3'd0, 32'hC000_0000);
        rd(3'd0, d); check("R4 ack only targeted", d, 32'h4900_0000);
        wr(3'd0, 32'h0900_0000);
        rd(3'd0, d); check("R4 ack src2", d, 32'h4100_0000);
        irq_src[1] = 1'b0;

        // R6 masked edge source src3 still latches but stays silent
        @(negedge clk); irq_src[2] = 1'b1;
        @(negedge clk); irq_src[2] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(3'd0, d); check("R6 masked pending", d, 32'h4180_0000);
        check("R6 masked level", {29'h0, irq_level}, 32'h0);
        iack(3'd0, v, vec); check("R9 level0 spurious", {24'h0, vec}, 32'd64);
        wr(3'd0, 32'h00E0_0000);
        rd(3'd0, d); check("R3 R4 prio load clears", d, 32'h4160_0000);

        // R10 base change
        wr(3'd5, 32'h0000_0080);
        rd(3'd5, d); check("R10 base readback", d, 32'h80);
        @(negedge clk); irq_src[8] = 1'b1;
        iack(3'd3, v, vec); check("R10 vector new base", {24'h0, vec}, 32'd137);

        // R4 level source unaffected by ack write
        wr(3'd1, 32'hB000_0000);
        rd(3'd1, d); check("R4 level stays pending", d, 32'hB650_7000);
        check("R4 level out", {29'h0, irq_level}, 32'd3);

        // R8 held request: one pulse then low
        @(negedge clk); iack_req = 1'b1; iack_level = 3'd3;
        @(negedge clk); check("R8 held first", {31'h0, iack_valid}, 32'h1);
        @(negedge clk); check("R8 held gap", {31'h0, iack_valid}, 32'h0);
        iack_req = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule